// File: doc/BRIEF.md
# Mask-Driven Bit Gather/Scatter Unit

This unit takes a source word and a mask word and does one of two data-dependent bit moves. In gather mode it reads the source bits at the positions where the mask holds a one and packs them, lowest mask position first, into the bottom of the result. In scatter mode it reads the source bits from the bottom up and places each one at the next set mask position, lowest first. Every other result bit is zero in both modes.

The datapath is 64 bits wide. A width-select input restricts an operation to the low 32 bits of both operands, and the result is zero-extended. The unit is sequential: it looks at one mask position per clock. A one-cycle `start` pulse latches the operands, the operation code and the width. `busy` then stays high for the scan, and a one-cycle `done` marks the edge at which `result` becomes final. An execution pipeline issues work to it and waits for `done`.

Top module: `pdx_unit`

## Requirements
- R1: With `op`=0 (gather), result bit j holds the source bit at the j-th lowest set mask position (j counted from 0). Result bits at and above the mask's population count are zero.
- R2: With `op`=1 (scatter), the result bit at the j-th lowest set mask position holds source bit j. Result bits where the mask is zero are zero.
- R3: Gathering an all-ones source gives 2^k−1, where k is the number of set mask bits. Scattering an all-ones source gives the mask itself.
- R4: Scattering the result of a gather under the same mask gives the source ANDed with the mask.
- R5: With `wide`=0, only bits 31:0 of `src` and `mask` are used, and `result[63:32]` is zero. With `wide`=1, all 64 bits are used. For source 0x202020204F4C4845 and mask 0xA080800302020001, a gather gives 133 when `wide`=1 and 5 when `wide`=0.
- R6: An all-zero mask (after width restriction) gives a zero result in both modes.
- R7: A `start` seen while `busy` is low is accepted, and `busy` is high from the next edge. `done` rises exactly 64 edges (`wide`=1) or 32 edges (`wide`=0) after the accepting edge. It lasts one cycle, and `busy` falls on the same edge.
- R8: A `start` seen while `busy` is high is ignored. The running operation keeps its operands, its mode and its completion time.
- R9: `op`, `wide`, `src` and `mask` are sampled only on the accepting edge. `result` holds its final value from `done` until the next accepted `start`.
- R10: After reset, `busy`, `done` and `result` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request pulse; accepted only when idle |
| op | input | 1 | 0 = gather, 1 = scatter |
| wide | input | 1 | 1 = 64-bit operands, 0 = low 32 bits |
| src | input | 64 | Source word |
| mask | input | 64 | Mask word |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle pulse: result is final |
| result | output | 64 | Gather or scatter result |

## Verification
The bench runs the fixed example operands in both widths, all-ones sources and zero masks, and a gather followed by a scatter of its output. A design that swapped the counter roles between the two modes would scatter gathered bits to the wrong places. One that ignored the width select would leak high-half bits into a 32-bit result, giving 133 instead of 5. Random operands in both widths and both modes are checked against reference functions. The cycle from start to `done` is counted every time, so an off-by-one scan length shows up. A second `start` is sent mid-scan with different operands, so a design that restarts or relatches would return the wrong value late. Operands are changed after `done`, so a result that is not held is caught.

// File: rtl/pdx_pkg.sv
package pdx_pkg;
    typedef enum logic {
        OP_GATHER  = 1'b0,
        OP_SCATTER = 1'b1
    } pdx_op_e;
endpackage

// File: rtl/pdx_seq.sv
// Scan sequencer: accepts a request when idle, walks the bit index, pulses done.
module pdx_seq #(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [IDX_W-1:0] last_idx,
    output logic             accept,
    output logic             busy,
    output logic             done,
    output logic [IDX_W-1:0] idx
);
    typedef struct packed {
        logic             busy;
        logic             done;
        logic [IDX_W-1:0] idx;
    } seq_t;

    seq_t s_d, s_q;

    assign accept = start & ~s_q.busy;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (accept) begin
            s_d.busy = 1'b1;
            s_d.idx  = '0;
        end else if (s_q.busy) begin
            if (s_q.idx == last_idx) begin
                s_d.busy = 1'b0;
                s_d.done = 1'b1;
            end else begin
                s_d.idx = s_q.idx + IDX_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy = s_q.busy;
    assign done = s_q.done;
    assign idx  = s_q.idx;

    // R7: done is a single-cycle pulse and never overlaps busy
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    a_r7_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && idx == '0));
    // R8: a running scan just advances, whatever start does
    a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && idx != last_idx) |=> (busy && idx == $past(idx) + IDX_W'(1)));
endmodule

// File: rtl/pdx_step.sv
// One scan step: handles mask position idx, moving one bit and bumping the packed count.
module pdx_step #(
    parameter int DATA_W = 64,
    parameter int IDX_W  = 6,
    parameter int CNT_W  = 7
) (
    input  pdx_pkg::pdx_op_e  op,
    input  logic [IDX_W-1:0]  idx,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [DATA_W-1:0] src,
    input  logic [DATA_W-1:0] mask,
    input  logic [DATA_W-1:0] acc,
    output logic [DATA_W-1:0] acc_nx,
    output logic [CNT_W-1:0]  cnt_nx
);
    logic [IDX_W-1:0] pack_pos;
    assign pack_pos = cnt[IDX_W-1:0];

    always_comb begin
        acc_nx = acc;
        cnt_nx = cnt;
        if (mask[idx]) begin
            if (op == pdx_pkg::OP_GATHER) acc_nx[pack_pos] = src[idx];
            else                          acc_nx[idx]      = src[pack_pos];
            cnt_nx = cnt + CNT_W'(1);
        end
    end
endmodule

// File: rtl/pdx_unit.sv
module pdx_unit #(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              op,
    input  logic              wide,
    input  logic [DATA_W-1:0] src,
    input  logic [DATA_W-1:0] mask,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] result
);
    localparam int HALF_W = DATA_W / 2;
    localparam int IDX_W  = $clog2(DATA_W);
    localparam int CNT_W  = $clog2(DATA_W + 1);

    typedef struct packed {
        pdx_pkg::pdx_op_e  op;
        logic              wide;
        logic [DATA_W-1:0] src;
        logic [DATA_W-1:0] mask;
        logic [DATA_W-1:0] acc;
        logic [CNT_W-1:0]  cnt;
    } unit_t;

    unit_t st_d, st_q;

    logic              accept;
    logic [IDX_W-1:0]  idx;
    logic [IDX_W-1:0]  last_idx;
    logic [DATA_W-1:0] size_keep;
    logic [DATA_W-1:0] acc_nx;
    logic [CNT_W-1:0]  cnt_nx;

    assign last_idx  = st_q.wide ? IDX_W'(DATA_W - 1) : IDX_W'(HALF_W - 1);
    assign size_keep = wide ? {DATA_W{1'b1}} : {{HALF_W{1'b0}}, {HALF_W{1'b1}}};

    pdx_seq #(.IDX_W(IDX_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .last_idx (last_idx),
        .accept   (accept),
        .busy     (busy),
        .done     (done),
        .idx      (idx)
    );

    pdx_step #(.DATA_W(DATA_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_step (
        .op     (st_q.op),
        .idx    (idx),
        .cnt    (st_q.cnt),
        .src    (st_q.src),
        .mask   (st_q.mask),
        .acc    (st_q.acc),
        .acc_nx (acc_nx),
        .cnt_nx (cnt_nx)
    );

    always_comb begin
        st_d = st_q;
        if (accept) begin
            st_d.op   = pdx_pkg::pdx_op_e'(op);
            st_d.wide = wide;
            st_d.src  = src & size_keep;
            st_d.mask = mask & size_keep;
            st_d.acc  = '0;
            st_d.cnt  = '0;
        end else if (busy) begin
            st_d.acc = acc_nx;
            st_d.cnt = cnt_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign result = st_q.acc;

    // R1: the packed count never runs ahead of the scan position
    a_r1_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (st_q.cnt <= CNT_W'(idx)));
    // R5: narrow operations leave the upper half clear
    a_r5_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !st_q.wide) |-> (result[DATA_W-1:HALF_W] == '0));
    // R6: an empty mask yields nothing
    a_r6_zero_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (done && st_q.mask == '0) |-> (result == '0));
    // R9: the result is held while idle and no request arrives
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(result));
endmodule

// File: tb/sim_pdx_unit.sv
`timescale 1ns/1ps
module sim_pdx_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        op = 1'b0;
    logic        wide = 1'b1;
    logic [63:0] src = '0;
    logic [63:0] mask = '0;
    logic        busy, done;
    logic [63:0] result;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    pdx_unit #(.DATA_W(64)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .wide(wide),
        .src(src), .mask(mask), .busy(busy), .done(done), .result(result)
    );

    function automatic logic [63:0] ref_gather(logic [63:0] s, logic [63:0] m, logic w);
        logic [63:0] r = '0;
        int k = 0;
        int n = w ? 64 : 32;
        for (int i = 0; i < n; i++)
            if (m[i]) begin r[k] = s[i]; k++; end
        return r;
    endfunction

    function automatic logic [63:0] ref_scatter(logic [63:0] s, logic [63:0] m, logic w);
        logic [63:0] r = '0;
        int k = 0;
        int n = w ? 64 : 32;
        for (int i = 0; i < n; i++)
            if (m[i]) begin r[i] = s[k]; k++; end
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // Issues one request; optionally fires a second start mid-scan with other operands.
    task automatic run(input logic o, input logic w, input logic [63:0] s, input logic [63:0] m,
                       input bit poke, output logic [63:0] res, output int cyc);
        @(negedge clk);
        op = o; wide = w; src = s; mask = m; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (!done && cyc < 200) begin
            if (poke && cyc == 5) begin
                op = ~o; wide = ~w; src = ~s; mask = ~m; start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        res = result;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=%h expected=%h", 64'd1, 64'd0);
        finish_run();
    end

    localparam logic [63:0] EHLO = 64'h202020204F4C4845;
    localparam logic [63:0] MSK  = 64'hA080800302020001;

    initial begin
        logic [63:0] r, r2, s, m, e;
        int cyc;
        logic o, w;
        void'($urandom(32'd1234));

        repeat (3) @(negedge clk);
        // R10: reset state
        chk(busy == 1'b0 && done == 1'b0 && result == '0, "R10", {busy, done, result[61:0]}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R5/R1: example gather in both widths
        run(1'b0, 1'b1, EHLO, MSK, 1'b0, r, cyc);
        chk(r == 64'd133, "R5 wide gather", r, 64'd133);
        chk(cyc == 64, "R7 wide latency", 64'(cyc), 64'd64);
        run(1'b0, 1'b0, EHLO, MSK, 1'b0, r2, cyc);
        chk(r2 == 64'd5, "R5 narrow gather", r2, 64'd5);
        chk(cyc == 32, "R7 narrow latency", 64'(cyc), 64'd32);

        // R4: round trip
        run(1'b1, 1'b1, r, MSK, 1'b0, r2, cyc);
        chk(r2 == (EHLO & MSK), "R4 round trip", r2, EHLO & MSK);

        // R3: all-ones source
        run(1'b0, 1'b1, '1, MSK, 1'b0, r, cyc);
        chk(r == 64'd511, "R3 gather ones", r, 64'd511);
        run(1'b1, 1'b1, '1, MSK, 1'b0, r, cyc);
        chk(r == MSK, "R3 scatter ones", r, MSK);
        run(1'b0, 1'b0, '1, MSK, 1'b0, r, cyc);
        chk(r == 64'd7, "R5 narrow gather ones", r, 64'd7);
        run(1'b1, 1'b0, '1, MSK, 1'b0, r, cyc);
        chk(r == {32'd0, MSK[31:0]}, "R5 narrow scatter ones", r, {32'd0, MSK[31:0]});

        // R6: zero masks (also narrow where only high half is set)
        run(1'b0, 1'b1, '1, '0, 1'b0, r, cyc);
        chk(r == '0, "R6 gather zero mask", r, 64'd0);
        run(1'b1, 1'b1, '1, '0, 1'b0, r, cyc);
        chk(r == '0, "R6 scatter zero mask", r, 64'd0);
        run(1'b1, 1'b0, '1, 64'hFFFF_FFFF_0000_0000, 1'b0, r, cyc);
        chk(r == '0, "R6 narrow high-only mask", r, 64'd0);

        // R8: second start mid-scan is ignored
        run(1'b1, 1'b1, EHLO, MSK, 1'b1, r, cyc);
        e = ref_scatter(EHLO, MSK, 1'b1);
        chk(r == e, "R8 ignored start value", r, e);
        chk(cyc == 64, "R8 ignored start latency", 64'(cyc), 64'd64);
        @(negedge clk);
        chk(busy == 1'b0, "R8 no restart", {63'd0, busy}, 64'd0);

        // R9: result held after done while inputs change
        op = 1'b0; wide = 1'b0; src = '0; mask = '1;
        repeat (4) @(negedge clk);
        chk(result == e, "R9 hold", result, e);

        // R1/R2/R5: random operands
        for (int t = 0; t < 40; t++) begin
            s = {$urandom(), $urandom()};
            m = {$urandom(), $urandom()};
            if (t % 4 == 1) m = m & {$urandom(), $urandom()};
            o = 1'($urandom());
            w = 1'($urandom());
            run(o, w, s, m, 1'b0, r, cyc);
            e = o ? ref_scatter(s, m, w) : ref_gather(s, m, w);
            if (o) chk(r == e, "R2 random scatter", r, e);
            else   chk(r == e, "R1 random gather", r, e);
            chk(cyc == (w ? 64 : 32), "R7 random latency", 64'(cyc), w ? 64'd64 : 64'd32);
        end

        finish_run();
    end
endmodule